// File: doc/BRIEF.md
# Synthesizer Control Register File

This block is the software-visible control register file for a multiplying clock source that feeds several fractional synthesizer outputs. It holds one main control word for the multiplier loop, one power-down word for the outputs, and a frequency word plus a post-divider word for each synthesizer output. Its outputs drive the configuration fields and the one-cycle load strobes consumed by the synthesizer datapaths, and report whether the main loop is bypassed, enabled and locked.

Output index 0 is the main multiplier output. Synthesizer outputs take indices 1 to NUM_OUT-1. The analog loop is not modelled. Lock is a settling counter: it raises the lock flag LOCK_CYCLES clock edges after the loop is enabled, or after it is retuned. An instance parameter inverts the meaning of the bypass bit, for loops whose bypass control is active low. The port is word addressed with byte offsets (address bits 1:0 are ignored). Reads are combinational. A write takes effect at the clock edge where `bus_wr` is high.

Top module: `clkgen_cfg_regs`

## Requirements
- R1: After reset the control word reads 0x0000_0004 (bypass bit 2 set) when INVERT_BYPASS is 0, and 0x0000_0000 when it is 1. In both cases `bypass_active` is 1. The power-down word reads with every implemented bit set (0x7E for 7 outputs). Frequency and divider words read 0 and `pll_locked` is 0.
- R2: The control word at offset 0x00 holds the multiplier in bits 31:16, the pre-divider in bits 15:8, enable in bit 3, bypass in bit 2 and loop control in bit 0. Bit 7 reads the lock flag. All other bits ignore writes and read 0. The fields appear on `mult_n`, `prediv_p`, `pll_en` and `loop_ctl`.
- R3: With INVERT_BYPASS 0, `bypass_active` equals control bit 2. With INVERT_BYPASS 1, `bypass_active` is the inverse of bit 2.
- R4: `ref_passthru` is 1 when `bypass_active` is 1, when the multiplier is 0, or when the pre-divider is 0. Otherwise it is 0, meaning the main output runs at reference / P × N.
- R5: A write that sets enable from the disabled state raises `pll_locked` exactly LOCK_CYCLES edges after the write edge. A write that clears enable drops `pll_locked` at the write edge. `pll_locked` is never 1 while enable is 0.
- R6: A write that keeps enable set but changes the multiplier or the pre-divider clears `pll_locked` at the write edge and restarts the full LOCK_CYCLES count. A write that keeps enable, multiplier and pre-divider unchanged leaves `pll_locked` unchanged.
- R7: The power-down word is at offset 0x04. Bit i, for i from 1 to NUM_OUT-1, powers down synthesizer output i when set and enables it when clear. Output i appears on `syn_pwrdn[i-1]`. Bit 0 and the bits above NUM_OUT-1 ignore writes and read 0.
- R8: Output i has its frequency word at offset 8·i and its divider word at offset 8·i+4. The frequency word holds the integer divider in bits 27:24 and the fraction in bits 23:0. The divider word holds the post-divider in bits 7:0. These fields appear on the `syn_*` port slices for output i, at slice index i-1.
- R9: Writing a frequency word with bit 31 set pulses `syn_freq_load[i-1]` for exactly one cycle after the write edge. Writing a divider word with bit 8 set pulses `syn_div_load[i-1]` in the same way. Both strobe bits always read back as 0, and frequency bits 30:28 and divider bits 31:9 read 0.
- R10: `syn_frac_present[i-1]` is 0 exactly when bits 27:0 of output i's frequency word are all zero, which marks an output without a fractional stage.
- R11: Reads of unimplemented word offsets (0x38 and up for 7 outputs) return 0, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wr | input | 1 | Write enable for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pll_en | output | 1 | Main loop enable |
| loop_ctl | output | 1 | Loop-control bit |
| bypass_active | output | 1 | Main loop is in bypass (polarity applied) |
| ref_passthru | output | 1 | Main output equals the reference rate |
| mult_n | output | 16 | Main multiplier N |
| prediv_p | output | 8 | Main pre-divider P |
| pll_locked | output | 1 | Lock flag from the settling counter |
| syn_pwrdn | output | NUM_OUT-1 | Per-output power-down |
| syn_int_div | output | 4·(NUM_OUT-1) | Integer divider per output |
| syn_frac | output | 24·(NUM_OUT-1) | Fractional divider per output |
| syn_post_div | output | 8·(NUM_OUT-1) | Post-divider per output |
| syn_frac_present | output | NUM_OUT-1 | Output has a fractional stage |
| syn_freq_load | output | NUM_OUT-1 | One-cycle frequency load strobe |
| syn_div_load | output | NUM_OUT-1 | One-cycle divider load strobe |

## Verification
A wrong field mapping or a wrong decode in this block shows up in the first read after a write: the data lands in a neighbour's word or an unimplemented offset, and it shows on the field ports in the same cycle. A settling counter that starts or stops on the wrong edge moves the rise of `pll_locked` by whole cycles, so the bench samples the edge before the expected rise and the edge of the rise. A strobe that fails to clear is visible one cycle after the write. A lost or inverted bypass polarity is visible directly at reset, on the two differently parameterised instances.

// File: rtl/clkgen_cfg_pkg.sv
package clkgen_cfg_pkg;

    localparam int WORD_W = 32;

    // field widths
    localparam int MULT_W = 16;
    localparam int PDIV_W = 8;
    localparam int IDIV_W = 4;
    localparam int FRAC_W = 24;
    localparam int POST_W = 8;

    // bit positions in the main control word
    localparam int CTL_N_LSB    = 16;
    localparam int CTL_P_LSB    = 8;
    localparam int CTL_LOCK_BIT = 7;
    localparam int CTL_EN_BIT   = 3;
    localparam int CTL_BYP_BIT  = 2;
    localparam int CTL_LOOP_BIT = 0;

    // bit positions in synthesizer words
    localparam int FRQ_LOAD_BIT = 31;
    localparam int FRQ_INT_LSB  = 24;
    localparam int DIV_LOAD_BIT = 8;

    typedef struct packed {
        logic [MULT_W-1:0] mult;
        logic [PDIV_W-1:0] prediv;
        logic              en;
        logic              byp;
        logic              loop;
    } main_ctl_t;

    typedef struct packed {
        logic [IDIV_W-1:0] idiv;
        logic [FRAC_W-1:0] frac;
    } freq_word_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTL,
        SEL_PWD,
        SEL_FREQ,
        SEL_DIV
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [4:0] slot;
    } reg_hit_t;

    function automatic main_ctl_t ctl_from_word(input logic [WORD_W-1:0] w);
        main_ctl_t c;
        c.mult   = w[CTL_N_LSB +: MULT_W];
        c.prediv = w[CTL_P_LSB +: PDIV_W];
        c.en     = w[CTL_EN_BIT];
        c.byp    = w[CTL_BYP_BIT];
        c.loop   = w[CTL_LOOP_BIT];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctl_to_word(input main_ctl_t c, input logic locked);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CTL_N_LSB +: MULT_W] = c.mult;
        w[CTL_P_LSB +: PDIV_W] = c.prediv;
        w[CTL_LOCK_BIT]        = locked;
        w[CTL_EN_BIT]          = c.en;
        w[CTL_BYP_BIT]         = c.byp;
        w[CTL_LOOP_BIT]        = c.loop;
        return w;
    endfunction

    function automatic freq_word_t freq_from_word(input logic [WORD_W-1:0] w);
        freq_word_t f;
        f.idiv = w[FRQ_INT_LSB +: IDIV_W];
        f.frac = w[FRAC_W-1:0];
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] freq_to_word(input freq_word_t f);
        logic [WORD_W-1:0] w;
        w = '0;
        w[FRQ_INT_LSB +: IDIV_W] = f.idiv;
        w[FRAC_W-1:0]            = f.frac;
        return w;
    endfunction

    function automatic logic rate_passthru(input logic bypassed,
                                           input logic [MULT_W-1:0] mult,
                                           input logic [PDIV_W-1:0] prediv);
        return bypassed || (mult == '0) || (prediv == '0);
    endfunction

endpackage

// File: rtl/clkgen_main_ctl.sv
module clkgen_main_ctl
    import clkgen_cfg_pkg::*;
#(
    parameter bit INVERT_BYPASS = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output main_ctl_t         ctl,
    output logic              restart,
    output logic              bypass_active,
    output logic              passthru
);

    // reset value of the bypass bit puts the loop in bypass for either polarity
    localparam logic BYP_RESET = INVERT_BYPASS ? 1'b0 : 1'b1;

    main_ctl_t nxt;
    logic      retune;
    logic      wdata_unused;

    assign nxt          = ctl_from_word(wdata);
    assign wdata_unused = ^{wdata[7:4], wdata[1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl.mult   <= '0;
            ctl.prediv <= '0;
            ctl.en     <= 1'b0;
            ctl.byp    <= BYP_RESET;
            ctl.loop   <= 1'b0;
        end else if (wr_en) begin
            ctl <= nxt;
        end
    end

    // settling restarts on enable, disable, or a change of N or P
    assign retune  = (nxt.mult != ctl.mult) || (nxt.prediv != ctl.prediv);
    assign restart = wr_en && (!nxt.en || !ctl.en || retune);

    generate
        if (INVERT_BYPASS) begin : g_byp_low
            assign bypass_active = ~ctl.byp;
        end else begin : g_byp_high
            assign bypass_active = ctl.byp;
        end
    endgenerate

    assign passthru = rate_passthru(bypass_active, ctl.mult, ctl.prediv);

endmodule

// File: rtl/clkgen_lock_timer.sv
module clkgen_lock_timer #(
    parameter int LOCK_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic restart,
    output logic locked
);

    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || !enable) begin
            cnt    <= '0;
            locked <= 1'b0;
        end else if (!locked) begin
            if (cnt == LAST) begin
                locked <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/clkgen_synth_slot.sv
module clkgen_synth_slot
    import clkgen_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              freq_wr,
    input  logic              div_wr,
    input  logic              pd_wr,
    input  logic              pd_val,
    input  logic [WORD_W-1:0] wdata,
    output freq_word_t        freq,
    output logic [POST_W-1:0] post_div,
    output logic              pwrdn,
    output logic              freq_load,
    output logic              div_load,
    output logic              frac_present
);

    logic wdata_unused;
    assign wdata_unused = ^wdata[30:28];

    always_ff @(posedge clk) begin
        if (rst) begin
            freq      <= '0;
            post_div  <= '0;
            pwrdn     <= 1'b1;
            freq_load <= 1'b0;
            div_load  <= 1'b0;
        end else begin
            freq_load <= freq_wr && wdata[FRQ_LOAD_BIT];
            div_load  <= div_wr && wdata[DIV_LOAD_BIT];
            if (freq_wr) begin
                freq <= freq_from_word(wdata);
            end
            if (div_wr) begin
                post_div <= wdata[POST_W-1:0];
            end
            if (pd_wr) begin
                pwrdn <= pd_val;
            end
        end
    end

    assign frac_present = (freq != '0);

endmodule

// File: rtl/clkgen_cfg_regs.sv
module clkgen_cfg_regs
    import clkgen_cfg_pkg::*;
#(
    parameter int NUM_OUT       = 7,
    parameter int ADDR_W        = 8,
    parameter int LOCK_CYCLES   = 1000,
    parameter bit INVERT_BYPASS = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic                       pll_en,
    output logic                       loop_ctl,
    output logic                       bypass_active,
    output logic                       ref_passthru,
    output logic [15:0]                mult_n,
    output logic [7:0]                 prediv_p,
    output logic                       pll_locked,
    output logic [NUM_OUT-2:0]         syn_pwrdn,
    output logic [4*(NUM_OUT-1)-1:0]   syn_int_div,
    output logic [24*(NUM_OUT-1)-1:0]  syn_frac,
    output logic [8*(NUM_OUT-1)-1:0]   syn_post_div,
    output logic [NUM_OUT-2:0]         syn_frac_present,
    output logic [NUM_OUT-2:0]         syn_freq_load,
    output logic [NUM_OUT-2:0]         syn_div_load
);

    localparam int NSYN   = NUM_OUT - 1;
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              addr_lsb_unused;
    reg_hit_t          hit;

    main_ctl_t         ctl;
    logic              restart;

    freq_word_t        slot_freq [NSYN];
    logic [POST_W-1:0] slot_post [NSYN];
    logic [NSYN-1:0]   slot_pd;

    assign widx            = bus_addr[ADDR_W-1:2];
    assign addr_lsb_unused = ^bus_addr[1:0];

    // address decode: word 0 control, word 1 power-down, 2i / 2i+1 per output
    always_comb begin
        hit.sel  = SEL_NONE;
        hit.slot = '0;
        if (widx == '0) begin
            hit.sel = SEL_CTL;
        end else if (widx == WIDX_W'(1)) begin
            hit.sel = SEL_PWD;
        end
        for (int k = 0; k < NSYN; k++) begin
            if (widx == WIDX_W'(2 * (k + 1))) begin
                hit.sel  = SEL_FREQ;
                hit.slot = 5'(k);
            end
            if (widx == WIDX_W'(2 * (k + 1) + 1)) begin
                hit.sel  = SEL_DIV;
                hit.slot = 5'(k);
            end
        end
    end

    clkgen_main_ctl #(
        .INVERT_BYPASS (INVERT_BYPASS)
    ) u_main (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (bus_wr && (hit.sel == SEL_CTL)),
        .wdata         (bus_wdata),
        .ctl           (ctl),
        .restart       (restart),
        .bypass_active (bypass_active),
        .passthru      (ref_passthru)
    );

    clkgen_lock_timer #(
        .LOCK_CYCLES (LOCK_CYCLES)
    ) u_lock (
        .clk     (clk),
        .rst     (rst),
        .enable  (ctl.en),
        .restart (restart),
        .locked  (pll_locked)
    );

    generate
        for (genvar g = 0; g < NSYN; g++) begin : g_slot
            clkgen_synth_slot u_slot (
                .clk          (clk),
                .rst          (rst),
                .freq_wr      (bus_wr && (hit.sel == SEL_FREQ) && (hit.slot == 5'(g))),
                .div_wr       (bus_wr && (hit.sel == SEL_DIV) && (hit.slot == 5'(g))),
                .pd_wr        (bus_wr && (hit.sel == SEL_PWD)),
                .pd_val       (bus_wdata[g + 1]),
                .wdata        (bus_wdata),
                .freq         (slot_freq[g]),
                .post_div     (slot_post[g]),
                .pwrdn        (slot_pd[g]),
                .freq_load    (syn_freq_load[g]),
                .div_load     (syn_div_load[g]),
                .frac_present (syn_frac_present[g])
            );
            assign syn_int_div[IDIV_W*g +: IDIV_W]  = slot_freq[g].idiv;
            assign syn_frac[FRAC_W*g +: FRAC_W]     = slot_freq[g].frac;
            assign syn_post_div[POST_W*g +: POST_W] = slot_post[g];
        end
    endgenerate

    assign syn_pwrdn = slot_pd;
    assign pll_en    = ctl.en;
    assign loop_ctl  = ctl.loop;
    assign mult_n    = ctl.mult;
    assign prediv_p  = ctl.prediv;

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (hit.sel)
            SEL_CTL:  bus_rdata = ctl_to_word(ctl, pll_locked);
            SEL_PWD:  bus_rdata[NSYN:1] = slot_pd;
            SEL_FREQ: begin
                for (int k = 0; k < NSYN; k++) begin
                    if (hit.slot == 5'(k)) bus_rdata = freq_to_word(slot_freq[k]);
                end
            end
            SEL_DIV: begin
                for (int k = 0; k < NSYN; k++) begin
                    if (hit.slot == 5'(k)) bus_rdata[POST_W-1:0] = slot_post[k];
                end
            end
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/clkgen_cfg_regs_chk.sv
module clkgen_cfg_regs_chk #(
    parameter int NUM_OUT = 7,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [31:0]        bus_wdata,
    input logic               pll_en,
    input logic               pll_locked,
    input logic               bypass_active,
    input logic               ref_passthru,
    input logic [15:0]        mult_n,
    input logic [7:0]         prediv_p,
    input logic [NUM_OUT-2:0] syn_freq_load,
    input logic [NUM_OUT-2:0] syn_div_load
);

    logic ctl_hit;
    assign ctl_hit = (bus_addr[ADDR_W-1:2] == '0);

    AST_LOCK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        pll_locked |-> pll_en); // R5

    AST_LOCK_RISE_STABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_locked) |-> ($past(pll_en) && $stable(mult_n) && $stable(prediv_p))); // R6

    AST_RETUNE_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && ctl_hit && bus_wdata[3] && pll_en &&
         ((bus_wdata[31:16] != mult_n) || (bus_wdata[15:8] != prediv_p))) |=> !pll_locked); // R6

    AST_BYPASS_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        bypass_active |-> ref_passthru); // R4

    AST_FREQ_STROBE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (syn_freq_load != '0) |-> ($past(bus_wr) && $past(bus_wdata[31]))); // R9

    AST_DIV_STROBE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (syn_div_load != '0) |-> ($past(bus_wr) && $past(bus_wdata[8]))); // R9

    AST_STROBE_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (((syn_freq_load != '0) || (syn_div_load != '0)) && !bus_wr)
        |=> ((syn_freq_load == '0) && (syn_div_load == '0))); // R9

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({syn_freq_load, syn_div_load})); // R9

endmodule

bind clkgen_cfg_regs clkgen_cfg_regs_chk #(
    .NUM_OUT (NUM_OUT),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .pll_en        (pll_en),
    .pll_locked    (pll_locked),
    .bypass_active (bypass_active),
    .ref_passthru  (ref_passthru),
    .mult_n        (mult_n),
    .prediv_p      (prediv_p),
    .syn_freq_load (syn_freq_load),
    .syn_div_load  (syn_div_load)
);

// File: tb/clkgen_cfg_regs_tb.sv
module clkgen_cfg_regs_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_OUT    = 7;
    localparam int ADDR_W     = 8;
    localparam int LOCK       = 20;
    localparam int NSYN       = NUM_OUT - 1;
    localparam int WATCHDOG   = 20000;

    // {address, write data, expected read-back}
    localparam int NVEC = 9;
    localparam logic [71:0] VEC [NVEC] = '{
        {8'h00, 32'hFFFF_FFFF, 32'hFFFF_FF0D},
        {8'h04, 32'hFFFF_FFFF, 32'h0000_007E},
        {8'h08, 32'hFFFF_FFFF, 32'h0FFF_FFFF},
        {8'h0C, 32'hFFFF_FFFF, 32'h0000_00FF},
        {8'h30, 32'h8123_4567, 32'h0123_4567},
        {8'h34, 32'h0000_01A5, 32'h0000_00A5},
        {8'h38, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'hFC, 32'h1234_5678, 32'h0000_0000},
        {8'h00, 32'h0012_0304, 32'h0012_0304}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;

    logic [31:0] rdata, rdata_i;
    logic en, en_i, loopc, loopc_i, byp, byp_i, pass, pass_i, lk, lk_i;
    logic [15:0] mn, mn_i;
    logic [7:0] pp, pp_i;
    logic [NSYN-1:0] pd, pd_i, fp, fp_i, fl, fl_i, dl, dl_i;
    logic [4*NSYN-1:0] idv, idv_i;
    logic [24*NSYN-1:0] frc, frc_i;
    logic [8*NSYN-1:0] pdv, pdv_i;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    clkgen_cfg_regs #(
        .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W), .LOCK_CYCLES(LOCK), .INVERT_BYPASS(1'b0)
    ) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata), .pll_en(en), .loop_ctl(loopc), .bypass_active(byp),
        .ref_passthru(pass), .mult_n(mn), .prediv_p(pp), .pll_locked(lk),
        .syn_pwrdn(pd), .syn_int_div(idv), .syn_frac(frc), .syn_post_div(pdv),
        .syn_frac_present(fp), .syn_freq_load(fl), .syn_div_load(dl)
    );

    clkgen_cfg_regs #(
        .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W), .LOCK_CYCLES(LOCK), .INVERT_BYPASS(1'b1)
    ) u_dut_inv (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_i), .pll_en(en_i), .loop_ctl(loopc_i), .bypass_active(byp_i),
        .ref_passthru(pass_i), .mult_n(mn_i), .prediv_p(pp_i), .pll_locked(lk_i),
        .syn_pwrdn(pd_i), .syn_int_div(idv_i), .syn_frac(frc_i), .syn_post_div(pdv_i),
        .syn_frac_present(fp_i), .syn_freq_load(fl_i), .syn_div_load(dl_i)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = rdata;
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v);  check("R1 ctl reset", v, 32'h0000_0004);
        v = rdata_i;   check("R1 ctl reset inverted", v, 32'h0);
        check("R1 bypass after reset", {30'b0, byp, byp_i}, 32'h3);
        rd(8'h04, v);  check("R1 pwdn reset", v, 32'h0000_007E);
        rd(8'h08, v);  check("R1 freq reset", v, 32'h0);
        rd(8'h34, v);  check("R1 div reset", v, 32'h0);
        check("R1 lock reset", {31'b0, lk}, 32'h0);

        // R2 R8 R11 layout table
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], v);
            check($sformatf("R2/R8/R11 table entry %0d", i), v, VEC[i][31:0]);
        end
        check("R2 field ports", {mn, pp, 5'b0, en, loopc, byp},
              {16'h0012, 8'h03, 5'b0, 1'b0, 1'b0, 1'b1});

        // R3 R4 polarity and pass-through
        wr(8'h00, 32'h0004_0100);
        check("R3 bypass bit clear", {30'b0, byp, byp_i}, 32'h1);
        check("R4 passthru with N=4 P=1", {30'b0, pass, pass_i}, 32'h1);
        wr(8'h00, 32'h0004_0104);
        check("R3 bypass bit set", {30'b0, byp, byp_i}, 32'h2);
        wr(8'h00, 32'h0000_0100);
        check("R4 passthru N zero", {31'b0, pass}, 32'h1);
        wr(8'h00, 32'h0005_0000);
        check("R4 passthru P zero", {31'b0, pass}, 32'h1);

        // R5 lock timing
        wr(8'h00, 32'h0004_0108);
        repeat (LOCK - 1) @(negedge clk);
        check("R5 lock one edge early", {31'b0, lk}, 32'h0);
        @(negedge clk);
        check("R5 lock on time", {31'b0, lk}, 32'h1);
        rd(8'h00, v);  check("R5 lock flag in bit 7", v, 32'h0004_0188);

        // R6 retune
        wr(8'h00, 32'h0004_0108);
        check("R6 same N P keeps lock", {31'b0, lk}, 32'h1);
        wr(8'h00, 32'h0005_0108);
        check("R6 N change drops lock", {31'b0, lk}, 32'h0);
        repeat (LOCK - 1) @(negedge clk);
        check("R6 relock one edge early", {31'b0, lk}, 32'h0);
        @(negedge clk);
        check("R6 relock on time", {31'b0, lk}, 32'h1);
        wr(8'h00, 32'h0005_0208);
        check("R6 P change drops lock", {31'b0, lk}, 32'h0);
        repeat (LOCK) @(negedge clk);
        wr(8'h00, 32'h0005_0200);
        check("R5 disable drops lock", {30'b0, en, lk}, 32'h0);

        // R9 R8 strobes and field ports
        wr(8'h10, 32'h8A00_00FF);
        check("R9 freq strobe slot 2", {26'b0, fl}, 32'h2);
        check("R8 int div slot 2", {28'b0, idv[7:4]}, 32'hA);
        check("R8 frac slot 2", {8'b0, frc[47:24]}, 32'h0000_00FF);
        @(negedge clk);
        check("R9 freq strobe cleared", {26'b0, fl}, 32'h0);
        rd(8'h10, v);  check("R9 strobe reads zero", v, 32'h0A00_00FF);
        wr(8'h1C, 32'h0000_0133);
        check("R9 div strobe slot 3", {26'b0, dl}, 32'h4);
        check("R8 post div slot 3", {24'b0, pdv[23:16]}, 32'h33);
        @(negedge clk);
        check("R9 div strobe cleared", {26'b0, dl}, 32'h0);

        // R10 fractional stage marker
        wr(8'h08, 32'h0);
        check("R10 zero word no frac", {31'b0, fp[0]}, 32'h0);
        wr(8'h08, 32'h0000_0001);
        check("R10 nonzero word frac", {31'b0, fp[0]}, 32'h1);
        wr(8'h08, 32'h8000_0000);
        check("R10 strobe only word no frac", {31'b0, fp[0]}, 32'h0);

        // R7 power-down mapping
        wr(8'h04, 32'h0000_0005);
        check("R7 pwrdn ports", {26'b0, pd}, 32'h2);
        rd(8'h04, v);  check("R7 pwrdn read", v, 32'h0000_0004);

        // R11 writes to unimplemented offsets ignored
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h04, v);  check("R11 pwrdn untouched", v, 32'h0000_0004);
        rd(8'h10, v);  check("R11 freq untouched", v, 32'h0A00_00FF);
        rd(8'h00, v);  check("R11 ctl untouched", v, 32'h0005_0200);
        rd(8'h40, v);  check("R11 unimplemented reads zero", v, 32'h0);
        check("R11 outputs untouched", {20'b0, fl, pd}, 32'h2);

        report();
    end

endmodule